// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single output line using an asynchronous frame. A processor writes a byte into a holding register and then hands it over by clearing an "empty" status flag. When a frame starts, the transmitter copies the byte into its own shift register. It sends a low start bit, the eight data bits least significant first, an optional parity bit and one high stop bit. Between frames the line rests high.

Because the holding register is freed the moment a frame starts, software can prepare the next byte while the current one is still on the line. Two interrupt requests follow the flags. One asks for data whenever the holding register is empty. The other reports that the line has gone quiet: a stop bit finished and no further byte had been handed over. Bit timing comes from an external enable strobe, and every line bit lasts exactly one strobe period.

Top module: `utx_core`

## Requirements
- R1: After reset the line is high, the empty flag and the end flag both read 1, both interrupt requests are high, and parity is off.
- R2: With parity off, a frame is one low start bit, data bits D0 to D7 in that order, then one high stop bit. Each bit is held for one bit-tick period.
- R3: With parity enabled and odd selection 0, a parity bit equal to the XOR of the eight data bits is sent between D7 and the stop bit.
- R4: With parity enabled and odd selection 1, the parity bit is the inverse of the XOR of the data bits.
- R5: When a frame starts, the byte leaves the holding register and the empty flag (status bit 7) returns to 1. `irq_empty` equals the empty flag.
- R6: If a byte is handed over while a frame is in progress, its start bit follows the stop bit directly, with no idle bit in between.
- R7: If no byte has been handed over when a stop bit ends, the end flag (status bit 6) becomes 1, `irq_end` rises, and the line stays high.
- R8: A status write with bit 7 at 0 while the empty flag is 1 hands the byte over and clears both flags. The frame begins at a later bit tick.
- R9: Writing only the data register, or writing status with bit 7 at 1, starts no frame and leaves both flags at 1.
- R10: Address 1 reads status as {empty, end, 0000, parity enable, odd select}. Status bits 1 and 0 are writable configuration. Address 0 reads back the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit-time boundary |
| cpu_we | input | 1 | Write strobe for the register port |
| cpu_sel | input | 1 | Register select: 0 holding register, 1 status/config |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial output line |
| irq_empty | output | 1 | Request for a new byte |
| irq_end | output | 1 | Transmission-finished request |

## Verification
The bench chains three bytes back to back. A design that reloads only from the idle state would insert one high bit between the frames, and the monitor counts idle samples before each start bit to catch that. It checks both parity senses on several bytes, so an inverted or missing parity bit shows up as a miscompared line sample. It writes the data register without a handover, and writes status with the empty bit still set. Any frame that appears after either of those is reported as a spurious start. It also confirms that a finished frame raises the end flag, and that the handover write clears that flag again.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int BYTE_W    = 8;
    localparam int ST_EMPTY  = 7;
    localparam int ST_END    = 6;
    localparam int CF_PAREN  = 1;
    localparam int CF_ODD    = 0;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PAR,
        LN_STOP
    } line_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    function automatic logic par_of(input logic [BYTE_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/utx_regs.sv
module utx_regs
    import utx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_we,
    input  logic          cpu_sel,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          load,
    input  logic          done,
    output logic [DW-1:0] hold,
    output logic          empty,
    output logic          end_flag,
    output frame_cfg_t    cfg,
    output logic [DW-1:0] cpu_rdata
);

    logic stat_wr;
    logic handover;

    assign stat_wr  = cpu_we && cpu_sel;
    assign handover = stat_wr && !cpu_wdata[ST_EMPTY] && empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            empty    <= 1'b1;
            end_flag <= 1'b1;
            cfg      <= '0;
        end else begin
            if (cpu_we && !cpu_sel) hold <= cpu_wdata;
            if (stat_wr) begin
                cfg.par_en  <= cpu_wdata[CF_PAREN];
                cfg.par_odd <= cpu_wdata[CF_ODD];
            end
            if (load)          empty <= 1'b1;
            else if (handover) empty <= 1'b0;
            if (handover)  end_flag <= 1'b0;
            else if (done) end_flag <= 1'b1;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel) begin
            cpu_rdata[ST_EMPTY] = empty;
            cpu_rdata[ST_END]   = end_flag;
            cpu_rdata[CF_PAREN] = cfg.par_en;
            cpu_rdata[CF_ODD]   = cfg.par_odd;
        end else begin
            cpu_rdata = hold;
        end
    end

    // R5: a frame start frees the holding register
    a_r5_load_frees: assert property (@(posedge clk) disable iff (rst)
        load |=> empty);
    // R5: a frame only starts on a byte that was handed over
    a_r5_load_needs_byte: assert property (@(posedge clk) disable iff (rst)
        load |-> !empty);
    // R8: while a byte waits, the end flag stays low
    a_r8_pending_not_end: assert property (@(posedge clk) disable iff (rst)
        !empty |-> !end_flag);

endmodule

// File: rtl/utx_engine.sv
module utx_engine
    import utx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          empty,
    input  logic [DW-1:0] hold,
    input  frame_cfg_t    cfg,
    output logic          load,
    output logic          done,
    output logic          txd
);

    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    line_state_e   state;
    logic [DW-1:0] shreg;
    logic          par_bit;
    logic          par_on;
    logic [CW-1:0] cnt;

    assign load = tick && !empty && (state == LN_IDLE || state == LN_STOP);
    assign done = tick &&  empty && (state == LN_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LN_IDLE;
            shreg   <= '0;
            par_bit <= 1'b0;
            par_on  <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            state   <= LN_START;
            shreg   <= hold;
            par_bit <= par_of(hold, cfg.par_odd);
            par_on  <= cfg.par_en;
        end else if (tick) begin
            unique case (state)
                LN_START: begin
                    state <= LN_DATA;
                    cnt   <= '0;
                end
                LN_DATA: begin
                    shreg <= shreg >> 1;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(DW - 1)) state <= par_on ? LN_PAR : LN_STOP;
                end
                LN_PAR:  state <= LN_STOP;
                LN_STOP: state <= LN_IDLE;
                default: state <= LN_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = shreg[0];
            LN_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // R1: the idle line rests at mark
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (state == LN_IDLE) |-> txd);
    // R2: the line only moves on a bit-time boundary
    a_r2_hold_bit: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd));
    // R2: the start bit always follows a frame load
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd);
    // R3: a parity slot only appears when parity was enabled at load
    a_r3_par_slot: assert property (@(posedge clk) disable iff (rst)
        (state == LN_PAR) |-> par_on);

endmodule

// File: rtl/utx_core.sv
module utx_core
    import utx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          cpu_we,
    input  logic          cpu_sel,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          txd,
    output logic          irq_empty,
    output logic          irq_end
);

    logic          load;
    logic          done;
    logic          empty;
    logic          end_flag;
    logic [DW-1:0] hold;
    frame_cfg_t    cfg;

    utx_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .load      (load),
        .done      (done),
        .hold      (hold),
        .empty     (empty),
        .end_flag  (end_flag),
        .cfg       (cfg),
        .cpu_rdata (cpu_rdata)
    );

    utx_engine #(.DW(DW)) u_engine (
        .clk   (clk),
        .rst   (rst),
        .tick  (bit_tick),
        .empty (empty),
        .hold  (hold),
        .cfg   (cfg),
        .load  (load),
        .done  (done),
        .txd   (txd)
    );

    assign irq_empty = empty;
    assign irq_end   = end_flag;

    // R7: once transmission has ended the line sits at mark
    a_r7_end_mark: assert property (@(posedge clk) disable iff (rst)
        end_flag |-> txd);
    // R7: the end flag rises only as a stop bit closes
    a_r7_end_on_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> $past(done));

endmodule

// File: tb/utx_core_test.sv
`timescale 1ns/1ps
module utx_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cpu_we = 1'b0;
    logic       cpu_sel = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       txd;
    logic       irq_empty;
    logic       irq_end;

    int n_chk  = 0;
    int n_fail = 0;
    bit ticking = 1'b0;

    typedef struct {
        logic [9:0] bits;
        int         n;
        bit         b2b;
        string      req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    utx_core uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .txd(txd),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bit-time strobe: one cycle high every four
    initial begin
        wait (ticking);
        forever begin
            repeat (3) @(posedge clk);
            #1 bit_tick = 1'b1;
            @(posedge clk);
            #1 bit_tick = 1'b0;
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(posedge clk);
        #1 cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(posedge clk);
        #1 cpu_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(posedge clk);
        #1 cpu_sel = sel;
        @(negedge clk);
        v = cpu_rdata;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic pen, input logic odd,
                        input bit b2b, input string req);
        exp_t e;
        e.bits = '0;
        for (int i = 0; i < 8; i++) e.bits[i] = d[i];
        if (pen) begin
            e.bits[8] = (^d) ^ odd;
            e.bits[9] = 1'b1;
            e.n = 10;
        end else begin
            e.bits[8] = 1'b1;
            e.n = 9;
        end
        e.b2b = b2b;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_empty(input string req);
        logic [7:0] v;
        bit seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            rd(1'b1, v);
            seen = v[7];
        end
        chk(seen, req, 0, 1);
        chk(irq_empty == 1'b1, "R5 irq_empty", irq_empty, 1);
    endtask

    // monitor: one line sample per bit period, just before its closing edge
    initial begin
        exp_t cur;
        bit in_frame = 1'b0;
        int idx = 0;
        int idle_run = 0;
        wait (ticking);
        forever begin
            @(negedge clk);
            if (bit_tick) begin
                if (!in_frame) begin
                    if (txd == 1'b0) begin
                        if (q.size() == 0) begin
                            chk(1'b0, "R9 spurious start", 0, 1);
                        end else begin
                            cur = q.pop_front();
                            if (cur.b2b) chk(idle_run == 0, "R6 idle gap", idle_run, 0);
                            in_frame = 1'b1;
                            idx = 0;
                        end
                    end else begin
                        idle_run++;
                    end
                end else begin
                    chk(txd == cur.bits[idx], cur.req, txd, cur.bits[idx]);
                    idx++;
                    if (idx == cur.n) begin
                        in_frame = 1'b0;
                        idle_run = 0;
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 line", txd, 1);
        chk(irq_empty && irq_end, "R1 irqs", {irq_empty, irq_end}, 3);
        rd(1'b1, v);
        chk(v == 8'hC0, "R1 R10 status", v, 8'hC0);
        ticking = 1'b1;

        // R9: byte written but not handed over
        wr(1'b0, 8'hA5);
        rd(1'b0, v);
        chk(v == 8'hA5, "R10 holding readback", v, 8'hA5);
        wr(1'b1, 8'h80);
        wait_ticks(12);
        rd(1'b1, v);
        chk(v == 8'hC0, "R9 flags untouched", v, 8'hC0);
        chk(txd == 1'b1, "R9 line mark", txd, 1);

        // R2/R8: plain frame, parity off
        push(8'hA5, 1'b0, 1'b0, 1'b0, "R2 frame A5");
        wr(1'b1, 8'h00);
        rd(1'b1, v);
        chk(v == 8'h00, "R8 handover clears flags", v, 8'h00);
        chk(irq_end == 1'b0, "R8 irq_end low", irq_end, 0);
        wait_empty("R5 empty after load");
        wait_ticks(14);
        rd(1'b1, v);
        chk(v == 8'hC0, "R7 end flag", v, 8'hC0);
        chk(irq_end && txd, "R7 irq_end and mark", {irq_end, txd}, 3);

        // R3: even parity
        wr(1'b0, 8'h3C);
        push(8'h3C, 1'b1, 1'b0, 1'b0, "R3 even parity 3C");
        wr(1'b1, 8'h02);
        wait_ticks(14);
        wr(1'b0, 8'h07);
        push(8'h07, 1'b1, 1'b0, 1'b0, "R3 even parity 07");
        wr(1'b1, 8'h02);
        wait_ticks(14);

        // R4: odd parity
        wr(1'b0, 8'h07);
        push(8'h07, 1'b1, 1'b1, 1'b0, "R4 odd parity 07");
        wr(1'b1, 8'h03);
        wait_ticks(14);
        rd(1'b1, v);
        chk(v == 8'hC3, "R10 R7 status with config", v, 8'hC3);

        // R6: three chained frames, parity off
        wr(1'b0, 8'h11);
        push(8'h11, 1'b0, 1'b0, 1'b0, "R6 chain 11");
        wr(1'b1, 8'h00);
        wait_empty("R5 chain load 1");
        wr(1'b0, 8'h22);
        push(8'h22, 1'b0, 1'b0, 1'b1, "R6 chain 22");
        wr(1'b1, 8'h00);
        wait_empty("R5 chain load 2");
        wr(1'b0, 8'h5A);
        push(8'h5A, 1'b0, 1'b0, 1'b1, "R6 chain 5A");
        wr(1'b1, 8'h00);
        wait_empty("R5 chain load 3");
        wait_ticks(14);
        rd(1'b1, v);
        chk(v == 8'hC0, "R7 end after chain", v, 8'hC0);
        chk(q.size() == 0, "R2 all frames seen", q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule